// File: doc/BRIEF.md
# Transparent Clock Residence Accumulator

This block sits in a switch node that forwards precision-time event messages. It does not re-time a local clock. Instead, it measures how long each event message stays inside the node and adds that dwell time to the cumulative correction value the message carries. Because every hop adds its own share, the final receiver sees the total delay the path introduced.

Packet handling is done by the logic around the block. When an event message enters, that logic presents the message's ID, its arrival timestamp and its incoming correction. When the message leaves, it presents the ID and the departure timestamp. The block matches the two events through a small table of messages in flight. One cycle after the departure event it returns the updated correction.

When peer-delay mode is selected, the configured delay of the upstream link is also added. That delay is the time from leaving the previous node to reaching this one.

Top module: `tc_residence_acc`

## Requirements
- R1: After reset, `upd_valid` and `miss_err` are 0 and `drop_cnt` is 0.
- R2: With `p2p_mode`=0, the updated correction equals the incoming correction plus the residence (departure timestamp minus arrival timestamp, in ns) multiplied by 65536. The correction is in units of 2^-16 ns.
- R3: With `p2p_mode`=1, the updated correction also includes `link_delay_ns` multiplied by 65536, on top of the R2 value.
- R4: A departure event whose ID is in flight gives `upd_valid`=1 for exactly the following cycle. In that cycle `upd_id` equals the departure ID and `upd_corr` holds the result.
- R5: Up to 4 messages with distinct IDs are tracked at once. Each departure is matched by ID, whatever the order of departure.
- R6: A departure event whose ID is not in flight gives no `upd_valid`. Instead, `miss_err` is 1 in the following cycle.
- R7: A new arrival is dropped when all 4 entries are occupied at the start of that cycle and its ID is not among them. `drop_cnt` then rises by 1, saturating at its maximum. A later departure of that ID misses.
- R8: An arrival whose ID is already in flight overwrites that entry's timestamp and correction. It uses no new entry and is never dropped.
- R9: A matched departure frees its entry, so a second departure of the same ID misses.
- R10: The residence is computed modulo 2^32 ns, so a departure timestamp that has wrapped past zero still gives the true residence.
- R11: The correction is a 64-bit two's-complement value. Negative incoming corrections are handled, and the sum wraps modulo 2^64.
- R12: An arrival and a departure in the same cycle are both handled. The departure only sees entries stored before that cycle, so a departure with the ID of a same-cycle arrival misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p2p_mode | input | 1 | 1 adds the upstream link delay to each result |
| link_delay_ns | input | 32 | Upstream link delay in ns |
| in_valid | input | 1 | Arrival event strobe |
| in_id | input | 16 | Arrival message ID |
| in_ts | input | 32 | Arrival timestamp in ns |
| in_corr | input | 64 | Incoming correction, 2^-16 ns units, signed |
| eg_valid | input | 1 | Departure event strobe |
| eg_id | input | 16 | Departure message ID |
| eg_ts | input | 32 | Departure timestamp in ns |
| upd_valid | output | 1 | Updated correction valid |
| upd_id | output | 16 | ID of the updated message |
| upd_corr | output | 64 | Updated correction |
| miss_err | output | 1 | Departure had no matching entry |
| drop_cnt | output | 8 | Saturating count of dropped arrivals |

## Verification
The bench builds the block with its defaults: four table entries, 32-bit timestamps, a 64-bit correction and peer-delay support compiled in. Four entries are few enough that the bench can fill the table completely, overflow it, and release the entries in every rotation and in reverse order. The 32-bit timestamp lets a wrap past zero be placed directly in the residence sweep. Signed corrections of both polarities are swept in both modes, and the expected sums are computed in 64-bit arithmetic.

// File: rtl/tc_res_pkg.sv
package tc_res_pkg;

   // Fractional bits of the correction value (units of 2^-16 ns)
   localparam int unsigned CORR_FRAC_BITS = 16;

   // Kind of result produced for a departure event
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_UPDATE = 2'd1,
      EV_MISS   = 2'd2
   } ev_kind_e;

   function automatic ev_kind_e classify(input logic eg_valid, input logic hit);
      if (!eg_valid)
         return EV_NONE;
      else if (hit)
         return EV_UPDATE;
      else
         return EV_MISS;
   endfunction

endpackage

// File: rtl/tc_sat_counter.sv
module tc_sat_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] CMAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (inc && (cnt_q != CMAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

endmodule

// File: rtl/tc_flight_table.sv
module tc_flight_table #(
   parameter int unsigned ID_W   = 16,
   parameter int unsigned TS_W   = 32,
   parameter int unsigned CORR_W = 64,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   // store side
   input  logic              ins_valid,
   input  logic [ID_W-1:0]   ins_id,
   input  logic [TS_W-1:0]   ins_ts,
   input  logic [CORR_W-1:0] ins_corr,
   output logic              ins_drop,
   // lookup side
   input  logic              look_valid,
   input  logic [ID_W-1:0]   look_id,
   output logic              look_hit,
   output logic [TS_W-1:0]   look_ts,
   output logic [CORR_W-1:0] look_corr
);

   logic [DEPTH-1:0]  occ;
   logic [ID_W-1:0]   id_a   [DEPTH];
   logic [TS_W-1:0]   ts_a   [DEPTH];
   logic [CORR_W-1:0] corr_a [DEPTH];

   logic [DEPTH-1:0]  look_match;
   logic [DEPTH-1:0]  dup_match;
   logic [DEPTH-1:0]  free_vec;
   logic [DEPTH-1:0]  first_free;
   logic [DEPTH-1:0]  ins_sel;
   logic              dup_any;
   logic              table_full;

   // Per-entry storage and comparators
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic              occ_r;
      logic [ID_W-1:0]   id_r;
      logic [TS_W-1:0]   ts_r;
      logic [CORR_W-1:0] corr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_r  <= 1'b0;
            id_r   <= '0;
            ts_r   <= '0;
            corr_r <= '0;
         end else begin
            if (look_valid && look_match[i])
               occ_r <= 1'b0;
            // a store in the same cycle takes precedence over the release
            if (ins_valid && ins_sel[i]) begin
               occ_r  <= 1'b1;
               id_r   <= ins_id;
               ts_r   <= ins_ts;
               corr_r <= ins_corr;
            end
         end
      end

      assign occ[i]        = occ_r;
      assign id_a[i]       = id_r;
      assign ts_a[i]       = ts_r;
      assign corr_a[i]     = corr_r;
      assign look_match[i] = occ_r && (id_r == look_id);
      assign dup_match[i]  = occ_r && (id_r == ins_id);
   end

   assign free_vec   = ~occ;
   assign first_free = free_vec & (~free_vec + 1'b1);
   assign dup_any    = |dup_match;
   assign table_full = &occ;
   assign ins_sel    = dup_any ? dup_match : first_free;
   assign ins_drop   = ins_valid && !dup_any && table_full;

   // Read mux: IDs are unique in the table so at most one entry matches
   always_comb begin
      look_ts   = '0;
      look_corr = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (look_match[i]) begin
            look_ts   = look_ts | ts_a[i];
            look_corr = look_corr | corr_a[i];
         end
      end
   end

   assign look_hit = |look_match;

   // Stored IDs are consumed only by the comparators above
   logic unused_ids;
   always_comb begin
      unused_ids = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         unused_ids = unused_ids ^ (^id_a[i]);
   end

endmodule

// File: rtl/tc_corr_calc.sv
module tc_corr_calc #(
   parameter int unsigned TS_W      = 32,
   parameter int unsigned CORR_W    = 64,
   parameter int unsigned LINK_W    = 32,
   parameter int unsigned FRAC_BITS = 16,
   parameter bit          P2P_EN    = 1'b1
) (
   input  logic [TS_W-1:0]   arr_ts,
   input  logic [TS_W-1:0]   dep_ts,
   input  logic [CORR_W-1:0] corr_in,
   input  logic [LINK_W-1:0] link_ns,
   input  logic              p2p_mode,
   output logic [CORR_W-1:0] corr_out
);

   localparam int unsigned RES_PAD  = CORR_W - TS_W;
   localparam int unsigned LINK_PAD = CORR_W - LINK_W;

   logic [TS_W-1:0]   res_ns;
   logic [CORR_W-1:0] res_term;
   logic [CORR_W-1:0] link_term;

   // modular difference copes with a wrapped departure timestamp
   assign res_ns   = dep_ts - arr_ts;
   assign res_term = {{RES_PAD{1'b0}}, res_ns} << FRAC_BITS;

   if (P2P_EN) begin : g_p2p
      assign link_term = p2p_mode ? ({{LINK_PAD{1'b0}}, link_ns} << FRAC_BITS) : '0;
   end else begin : g_e2e_only
      logic unused_link;
      assign unused_link = ^{link_ns, p2p_mode};
      assign link_term   = '0;
   end

   assign corr_out = corr_in + res_term + link_term;

endmodule

// File: rtl/tc_residence_acc.sv
module tc_residence_acc
   import tc_res_pkg::*;
#(
   parameter int unsigned ID_W      = 16,
   parameter int unsigned TS_W      = 32,
   parameter int unsigned CORR_W    = 64,
   parameter int unsigned LINK_W    = 32,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned DROP_W    = 8,
   parameter bit          P2P_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p2p_mode,
   input  logic [LINK_W-1:0] link_delay_ns,
   input  logic              in_valid,
   input  logic [ID_W-1:0]   in_id,
   input  logic [TS_W-1:0]   in_ts,
   input  logic [CORR_W-1:0] in_corr,
   input  logic              eg_valid,
   input  logic [ID_W-1:0]   eg_id,
   input  logic [TS_W-1:0]   eg_ts,
   output logic              upd_valid,
   output logic [ID_W-1:0]   upd_id,
   output logic [CORR_W-1:0] upd_corr,
   output logic              miss_err,
   output logic [DROP_W-1:0] drop_cnt
);

   localparam int unsigned FRAC_BITS = CORR_FRAC_BITS;

   // Elaboration-time parameter checks
   if (DEPTH < 1) begin : g_bad_depth
      $error("tc_residence_acc: DEPTH must be at least 1");
   end
   if (TS_W + FRAC_BITS >= CORR_W) begin : g_bad_ts
      $error("tc_residence_acc: shifted residence must fit the correction");
   end
   if (LINK_W + FRAC_BITS >= CORR_W) begin : g_bad_link
      $error("tc_residence_acc: shifted link delay must fit the correction");
   end
   if (DROP_W < 1 || ID_W < 1) begin : g_bad_w
      $error("tc_residence_acc: counter and ID widths must be positive");
   end

   logic              drop_pulse;
   logic              hit;
   logic [TS_W-1:0]   hit_ts;
   logic [CORR_W-1:0] hit_corr;
   logic [CORR_W-1:0] new_corr;
   ev_kind_e          ev_kind;

   tc_flight_table #(
      .ID_W   (ID_W),
      .TS_W   (TS_W),
      .CORR_W (CORR_W),
      .DEPTH  (DEPTH)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_valid  (in_valid),
      .ins_id     (in_id),
      .ins_ts     (in_ts),
      .ins_corr   (in_corr),
      .ins_drop   (drop_pulse),
      .look_valid (eg_valid),
      .look_id    (eg_id),
      .look_hit   (hit),
      .look_ts    (hit_ts),
      .look_corr  (hit_corr)
   );

   tc_corr_calc #(
      .TS_W      (TS_W),
      .CORR_W    (CORR_W),
      .LINK_W    (LINK_W),
      .FRAC_BITS (FRAC_BITS),
      .P2P_EN    (P2P_EN)
   ) u_calc (
      .arr_ts   (hit_ts),
      .dep_ts   (eg_ts),
      .corr_in  (hit_corr),
      .link_ns  (link_delay_ns),
      .p2p_mode (p2p_mode),
      .corr_out (new_corr)
   );

   tc_sat_counter #(
      .W (DROP_W)
   ) u_drops (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (drop_pulse),
      .count (drop_cnt)
   );

   assign ev_kind = classify(eg_valid, hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_valid <= 1'b0;
         miss_err  <= 1'b0;
         upd_id    <= '0;
         upd_corr  <= '0;
      end else begin
         upd_valid <= (ev_kind == EV_UPDATE);
         miss_err  <= (ev_kind == EV_MISS);
         if (ev_kind == EV_UPDATE) begin
            upd_id   <= eg_id;
            upd_corr <= new_corr;
         end
      end
   end

endmodule

// File: rtl/tc_residence_acc_chk.sv
module tc_residence_acc_chk #(
   parameter int unsigned ID_W   = 16,
   parameter int unsigned TS_W   = 32,
   parameter int unsigned CORR_W = 64,
   parameter int unsigned LINK_W = 32,
   parameter int unsigned DROP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              p2p_mode,
   input logic [LINK_W-1:0] link_delay_ns,
   input logic              in_valid,
   input logic [ID_W-1:0]   in_id,
   input logic [TS_W-1:0]   in_ts,
   input logic [CORR_W-1:0] in_corr,
   input logic              eg_valid,
   input logic [ID_W-1:0]   eg_id,
   input logic [TS_W-1:0]   eg_ts,
   input logic              upd_valid,
   input logic [ID_W-1:0]   upd_id,
   input logic [CORR_W-1:0] upd_corr,
   input logic              miss_err,
   input logic [DROP_W-1:0] drop_cnt
);

   // R4: a result only appears the cycle after a departure event
   a_r4_valid_after_egress: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $past(eg_valid));

   // R4: the result carries the departure ID
   a_r4_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_id == $past(eg_id)));

   // R4 and R6: every departure is answered by exactly one of the two outcomes
   a_r4_egress_answered: assert property (@(posedge clk) disable iff (!rst_n)
      eg_valid |=> (upd_valid ^ miss_err));

   // R6: a miss only follows a departure event
   a_r6_miss_after_egress: assert property (@(posedge clk) disable iff (!rst_n)
      miss_err |-> $past(eg_valid));

   // R7: the drop count moves by at most one per cycle
   a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1));

   // R7: the drop count only moves after an arrival event
   a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> $past(in_valid));

   // Inputs not referenced by any property
   logic unused_chk;
   assign unused_chk = ^{p2p_mode, link_delay_ns, in_id, in_ts, in_corr, eg_ts, upd_corr};

endmodule

bind tc_residence_acc tc_residence_acc_chk #(
   .ID_W   (ID_W),
   .TS_W   (TS_W),
   .CORR_W (CORR_W),
   .LINK_W (LINK_W),
   .DROP_W (DROP_W)
) u_chk (.*);

// File: tb/tb_tc_residence_acc.sv
`timescale 1ns/1ps
module tb_tc_residence_acc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p2p_mode = 1'b0;
   logic [31:0] link_delay_ns = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_id = '0;
   logic [31:0] in_ts = '0;
   logic [63:0] in_corr = '0;
   logic        eg_valid = 1'b0;
   logic [15:0] eg_id = '0;
   logic [31:0] eg_ts = '0;
   logic        upd_valid;
   logic [15:0] upd_id;
   logic [63:0] upd_corr;
   logic        miss_err;
   logic [7:0]  drop_cnt;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tc_residence_acc dut (
      .clk (clk), .rst_n (rst_n), .p2p_mode (p2p_mode), .link_delay_ns (link_delay_ns),
      .in_valid (in_valid), .in_id (in_id), .in_ts (in_ts), .in_corr (in_corr),
      .eg_valid (eg_valid), .eg_id (eg_id), .eg_ts (eg_ts),
      .upd_valid (upd_valid), .upd_id (upd_id), .upd_corr (upd_corr),
      .miss_err (miss_err), .drop_cnt (drop_cnt)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [63:0] c, input logic [31:0] t_in,
                                         input logic [31:0] t_out, input bit mode, input logic [31:0] lk);
      logic [31:0] res;
      res = t_out - t_in;
      return c + ({32'h0, res} << 16) + (mode ? ({32'h0, lk} << 16) : 64'h0);
   endfunction

   task automatic arrive(input logic [15:0] id, input logic [31:0] ts, input logic [63:0] c);
      @(negedge clk);
      in_valid = 1'b1; in_id = id; in_ts = ts; in_corr = c;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // departure; outputs checked at the next falling edge
   task automatic depart(input logic [15:0] id, input logic [31:0] ts,
                         input bit exp_hit, input logic [63:0] exp_c, input string req);
      @(negedge clk);
      eg_valid = 1'b1; eg_id = id; eg_ts = ts;
      @(negedge clk);
      eg_valid = 1'b0;
      chk(upd_valid == exp_hit, req, {63'h0, upd_valid}, {63'h0, exp_hit});
      chk(miss_err == !exp_hit, req, {63'h0, miss_err}, {63'h0, !exp_hit});
      if (exp_hit) begin
         chk(upd_id == id, req, {48'h0, upd_id}, {48'h0, id});
         chk(upd_corr == exp_c, req, upd_corr, exp_c);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] ts4 [4];
      logic [63:0] c4  [4];
      logic [7:0]  d0;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(upd_valid == 1'b0, "R1", {63'h0, upd_valid}, 64'h0);
      chk(miss_err == 1'b0, "R1", {63'h0, miss_err}, 64'h0);
      chk(drop_cnt == 8'h0, "R1", {56'h0, drop_cnt}, 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R10 R11: sweep residence, sign of correction and mode
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 8; k++) begin
            logic [31:0] ta, tb, lk;
            logic [63:0] c;
            ta = (k == 0) ? 32'hFFFF_FFF0 : 32'(k) * 32'h2468_1357;   // k==0 wraps (R10)
            tb = ta + 32'(k * k * 100003 + 64);
            c  = (k % 2 == 1) ? -(64'(k) * 64'd123456789) : 64'(k) * 64'd99999; // R11
            if (k == 7) c = 64'h7FFF_FFFF_FFFF_FF00;                     // wraps past max
            lk = 32'(1000 + k * 7);
            p2p_mode = m[0];
            link_delay_ns = lk;
            arrive(16'(k + 1), ta, c);
            depart(16'(k + 1), tb, 1'b1, model(c, ta, tb, m[0], lk), m == 0 ? "R2" : "R3");
         end
      end
      p2p_mode = 1'b0;

      // R5 R4: four messages in flight, released in every rotation and reversed
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < 4; i++) begin
            ts4[i] = 32'(1000 * p + 17 * i);
            c4[i]  = 64'(i * 5000) - 64'd7000;
            arrive(16'(16'h100 + i), ts4[i], c4[i]);
         end
         for (int j = 0; j < 4; j++) begin
            int i;
            i = (p < 4) ? (j + p) % 4 : (3 - ((j + p) % 4));
            depart(16'(16'h100 + i), ts4[i] + 32'(300 + 11 * j), 1'b1,
                   model(c4[i], ts4[i], ts4[i] + 32'(300 + 11 * j), 1'b0, 32'h0), "R5");
         end
      end

      // R6: unknown ID
      depart(16'hBEEF, 32'h10, 1'b0, 64'h0, "R6");

      // R7: table full, new ID dropped and counted, later departure misses
      for (int i = 0; i < 4; i++) arrive(16'(16'h200 + i), 32'(i), 64'h0);
      d0 = drop_cnt;
      arrive(16'h2FF, 32'h50, 64'h0);
      chk(drop_cnt == d0 + 8'd1, "R7", {56'h0, drop_cnt}, {56'h0, d0 + 8'd1});
      depart(16'h2FF, 32'h60, 1'b0, 64'h0, "R7");

      // R8: rewriting an ID in flight while full is accepted with new values
      d0 = drop_cnt;
      arrive(16'h202, 32'h1000, 64'd4242);
      chk(drop_cnt == d0, "R8", {56'h0, drop_cnt}, {56'h0, d0});
      depart(16'h202, 32'h1100, 1'b1, model(64'd4242, 32'h1000, 32'h1100, 1'b0, 32'h0), "R8");

      // R9: second departure of a consumed ID misses
      depart(16'h202, 32'h1200, 1'b0, 64'h0, "R9");
      for (int i = 0; i < 4; i++)
         if (i != 2) depart(16'(16'h200 + i), 32'(i + 40), 1'b1,
                            model(64'h0, 32'(i), 32'(i + 40), 1'b0, 32'h0), "R9");

      // R12: same-cycle arrival and departure
      arrive(16'h300, 32'd500, 64'd77);
      @(negedge clk);
      in_valid = 1'b1; in_id = 16'h301; in_ts = 32'd900; in_corr = 64'd5;
      eg_valid = 1'b1; eg_id = 16'h300; eg_ts = 32'd950;
      @(negedge clk);
      in_valid = 1'b0; eg_valid = 1'b0;
      chk(upd_valid == 1'b1, "R12", {63'h0, upd_valid}, 64'h1);
      chk(upd_corr == model(64'd77, 32'd500, 32'd950, 1'b0, 32'h0), "R12", upd_corr,
          model(64'd77, 32'd500, 32'd950, 1'b0, 32'h0));
      @(negedge clk);
      in_valid = 1'b1; in_id = 16'h302; in_ts = 32'd10; in_corr = 64'd0;
      eg_valid = 1'b1; eg_id = 16'h302; eg_ts = 32'd20;
      @(negedge clk);
      in_valid = 1'b0; eg_valid = 1'b0;
      chk(miss_err == 1'b1, "R12", {63'h0, miss_err}, 64'h1);
      depart(16'h301, 32'd1000, 1'b1, model(64'd5, 32'd900, 32'd1000, 1'b0, 32'h0), "R12");
      depart(16'h302, 32'd30, 1'b1, model(64'd0, 32'd10, 32'd30, 1'b0, 32'h0), "R12");

      // R4: the valid pulse lasts a single cycle
      @(negedge clk);
      chk(upd_valid == 1'b0, "R4", {63'h0, upd_valid}, 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule